// File: doc/BRIEF.md
# PLL Lock Monitor with Automatic Clock Bypass

This block judges whether a phase-locked loop has reached frequency lock. Two single-cycle edge strobes enter it, both already in a fast sampling clock domain. One marks edges of the PLL feedback clock and the other marks edges of the reference clock. The reference strobe passes through a programmable divider. Each divided-reference interval is one comparison period. A period is good when it holds exactly one feedback edge. The lock flag is raised only after a long unbroken run of good periods, and it drops on the first bad one.

When lock drops, the block sends a single-cycle event toward an error-signaling collector. It also drives the select line of a downstream glitch-free clock mux, where 1 selects the PLL output and 0 selects the reference. With automatic bypass enabled, that select follows the lock flag: it falls back to the reference on lock loss and returns to the PLL on relock. With automatic bypass off, software sets the select directly. A small register port holds the control bits and the divider value, and reports the lock flag.

Top module: `pll_lock_guard`

## Requirements
- R1: The divider register (address 1, bits [5:0], value D) makes each comparison period span D+1 reference strobes and end on a reference strobe. D = 0 gives one period per reference strobe.
- R2: A period that holds zero feedback strobes, or two or more, is a slip. A feedback strobe in the same cycle as the closing reference strobe belongs to the period that is closing.
- R3: `pll_locked` rises one cycle after the close of the 128th consecutive slip-free period and stays high while no slip occurs.
- R4: A slip pulls `pll_locked` low one cycle after the slipping period closes. Lock then needs a fresh run of 128 slip-free periods.
- R5: Reads are combinational on `reg_addr`. Address 0 returns {sw_sel, auto_bypass} in bits [1:0]. Address 1 returns the divider. Address 2 returns the lock flag in bit 0. Address 3 reads zero. Writes to addresses 2 and 3 have no effect.
- R6: `lock_lost_evt` is a one-cycle pulse, issued in the same cycle that `pll_locked` goes from 1 to 0. A slip while already unlocked gives no pulse.
- R7: With auto_bypass (address 0, bit 0) set, `clk_sel` equals `pll_locked`. It is 0 (reference) while unlocked and 1 (PLL output) while locked.
- R8: With auto_bypass clear, `clk_sel` equals sw_sel (address 0, bit 1) whatever the lock state.
- R9: After reset, lock is low, the slip-free run is zero, every register is zero, and `clk_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_edge | input | 1 | Reference clock edge strobe |
| fb_edge | input | 1 | PLL feedback clock edge strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| pll_locked | output | 1 | Frequency lock flag |
| lock_lost_evt | output | 1 | One-cycle lock-loss event |
| clk_sel | output | 1 | Clock mux select, 1 = PLL output, 0 = reference |

## Verification
The feedback stream is first applied at exactly one edge per divided period, with divider values 0 and 3. This shows that the divider sets the comparison window and that lock comes only after the full run. Single injected extra feedback edges and single missing feedback edges are then applied. An extra edge shows that a double edge is treated as a slip. A missing edge applied while already unlocked shows that no second event is raised. Toggling the bypass and software select bits across lock and unlock tells automatic bypass apart from manual selection. A behavioural model compares every output on every cycle.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
    localparam int DIV_W   = 6;
    localparam int RUN_LEN = 128;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIV    = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;

    localparam int CTRL_AUTO_BIT = 0;
    localparam int CTRL_SW_BIT   = 1;
endpackage

// File: rtl/plg_ref_divider.sv
module plg_ref_divider #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_edge,
    input  logic [DIV_W-1:0] div_val,
    output logic             div_edge
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t state_d, state_q;

    always_comb begin
        state_d  = state_q;
        div_edge = ref_edge && (state_q.cnt >= div_val);
        if (ref_edge) begin
            if (div_edge) state_d.cnt = '0;
            else          state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/plg_slip_detector.sv
module plg_slip_detector (
    input  logic clk,
    input  logic rst_n,
    input  logic div_edge,
    input  logic fb_edge,
    output logic period_end,
    output logic period_slip
);
    typedef struct packed {
        logic [1:0] fb_cnt;
    } slip_state_t;

    slip_state_t state_d, state_q;
    logic [1:0]  cnt_in;

    always_comb begin
        state_d = state_q;
        if (fb_edge && state_q.fb_cnt != 2'd2) cnt_in = state_q.fb_cnt + 2'd1;
        else                                   cnt_in = state_q.fb_cnt;
        period_end  = div_edge;
        period_slip = div_edge && (cnt_in != 2'd1);
        if (div_edge) state_d.fb_cnt = 2'd0;
        else          state_d.fb_cnt = cnt_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/plg_lock_tracker.sv
module plg_lock_tracker #(
    parameter int RUN_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_end,
    input  logic period_slip,
    output logic locked,
    output logic lost_evt
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             lock;
        logic             evt;
    } trk_state_t;

    trk_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.evt = 1'b0;
        if (period_end) begin
            if (period_slip) begin
                state_d.run  = '0;
                state_d.lock = 1'b0;
                state_d.evt  = state_q.lock;
            end else begin
                if (state_q.run != RUN_W'(RUN_LEN)) state_d.run = state_q.run + 1'b1;
                if (state_d.run == RUN_W'(RUN_LEN)) state_d.lock = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign locked   = state_q.lock;
    assign lost_evt = state_q.evt;
endmodule

// File: rtl/plg_ctrl_regs.sv
module plg_ctrl_regs
    import pll_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              locked,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              auto_en,
    output logic              sw_sel,
    output logic [DIV_W-1:0]  div_val
);
    typedef struct packed {
        logic             auto_en;
        logic             sw_sel;
        logic [DIV_W-1:0] div;
    } reg_state_t;

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (reg_we) begin
            if (reg_addr == ADDR_CTRL) begin
                state_d.auto_en = reg_wdata[CTRL_AUTO_BIT];
                state_d.sw_sel  = reg_wdata[CTRL_SW_BIT];
            end else if (reg_addr == ADDR_DIV) begin
                state_d.div = reg_wdata[DIV_W-1:0];
            end
        end
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_AUTO_BIT] = state_q.auto_en;
                reg_rdata[CTRL_SW_BIT]   = state_q.sw_sel;
            end
            ADDR_DIV:    reg_rdata[DIV_W-1:0] = state_q.div;
            ADDR_STATUS: reg_rdata[0] = locked;
            default:     reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign auto_en = state_q.auto_en;
    assign sw_sel  = state_q.sw_sel;
    assign div_val = state_q.div;
endmodule

// File: rtl/pll_lock_guard.sv
module pll_lock_guard
    import pll_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_edge,
    input  logic              fb_edge,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pll_locked,
    output logic              lock_lost_evt,
    output logic              clk_sel
);
    logic             div_edge;
    logic             period_end;
    logic             period_slip;
    logic             auto_en;
    logic             sw_sel;
    logic [DIV_W-1:0] div_val;

    plg_ref_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge),
        .div_val(div_val), .div_edge(div_edge)
    );

    plg_slip_detector u_slip (
        .clk(clk), .rst_n(rst_n), .div_edge(div_edge), .fb_edge(fb_edge),
        .period_end(period_end), .period_slip(period_slip)
    );

    plg_lock_tracker #(.RUN_LEN(RUN_LEN)) u_trk (
        .clk(clk), .rst_n(rst_n), .period_end(period_end),
        .period_slip(period_slip), .locked(pll_locked), .lost_evt(lock_lost_evt)
    );

    plg_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .locked(pll_locked), .reg_rdata(reg_rdata),
        .auto_en(auto_en), .sw_sel(sw_sel), .div_val(div_val)
    );

    always_comb begin
        if (auto_en) clk_sel = pll_locked;
        else         clk_sel = sw_sel;
    end
endmodule

// File: rtl/pll_lock_guard_chk.sv
module pll_lock_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic pll_locked,
    input logic lock_lost_evt,
    input logic clk_sel,
    input logic auto_en,
    input logic sw_sel,
    input logic period_end,
    input logic period_slip
);
    assert_evt_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lost_evt |-> (!pll_locked && $past(pll_locked)));

    assert_fall_has_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_locked) |-> lock_lost_evt);

    assert_slip_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && period_slip) |=> !pll_locked);

    assert_rise_after_good_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_locked) |-> $past(period_end && !period_slip));

    assert_sel_auto_R7: assert property (@(posedge clk) disable iff (!rst_n)
        auto_en |-> (clk_sel == pll_locked));

    assert_sel_manual_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |-> (clk_sel == sw_sel));
endmodule

bind pll_lock_guard pll_lock_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked),
    .lock_lost_evt(lock_lost_evt), .clk_sel(clk_sel), .auto_en(auto_en),
    .sw_sel(sw_sel), .period_end(period_end), .period_slip(period_slip)
);

// File: tb/pll_lock_guard_test.sv
module pll_lock_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_edge = 1'b0;
    logic       fb_edge = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd2;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       pll_locked;
    logic       lock_lost_evt;
    logic       clk_sel;

    always #2.5 clk = ~clk;

    pll_lock_guard uut (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pll_locked(pll_locked),
        .lock_lost_evt(lock_lost_evt), .clk_sel(clk_sel)
    );

    int n_vec = 0;
    int n_bad = 0;
    int n_evt = 0;
    bit done = 0;

    // behavioural reference model
    int m_rc = 0, m_fb = 0, m_run = 0, m_lock = 0, m_evt = 0;
    int m_auto = 0, m_sw = 0, m_div = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rc = 0; m_fb = 0; m_run = 0; m_lock = 0; m_evt = 0;
            m_auto = 0; m_sw = 0; m_div = 0;
        end else begin
            int hit, fbn;
            hit = (ref_edge && m_rc >= m_div) ? 1 : 0;
            if (ref_edge) m_rc = hit ? 0 : m_rc + 1;
            fbn = m_fb + (fb_edge ? 1 : 0);
            if (fbn > 2) fbn = 2;
            m_evt = 0;
            if (hit) begin
                if (fbn != 1) begin
                    m_evt = m_lock; m_run = 0; m_lock = 0;
                end else begin
                    if (m_run < 128) m_run++;
                    if (m_run == 128) m_lock = 1;
                end
                m_fb = 0;
            end else m_fb = fbn;
            if (reg_we) begin
                if (reg_addr == 2'd0) begin m_auto = reg_wdata[0]; m_sw = reg_wdata[1]; end
                else if (reg_addr == 2'd1) m_div = reg_wdata[5:0];
            end
        end
    end

    task automatic check_eq(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata();
        case (reg_addr)
            2'd0: return m_auto | (m_sw << 1);
            2'd1: return m_div;
            2'd2: return m_lock;
            default: return 0;
        endcase
    endfunction

    // stimulus generator state
    int ph = 0, sr = 0, gen_div = 0;
    bit fb_due = 0, skip_once = 0, extra_once = 0, extra_arm = 0;

    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            check_eq("R3/R4 lock", pll_locked, m_lock);
            check_eq("R6 event", lock_lost_evt, m_evt);
            check_eq(m_auto ? "R7 sel" : "R8 sel", clk_sel, m_auto ? m_lock : m_sw);
            check_eq("R5 rdata", reg_rdata, exp_rdata());
            if (lock_lost_evt) n_evt++;
        end
        ref_edge = 0; fb_edge = 0;
        if (ph == 0) begin
            ref_edge = 1;
            if (sr % (gen_div + 1) == 0) fb_due = 1;
            sr++;
        end
        if (ph == 2 && fb_due) begin
            fb_due = 0;
            if (skip_once) skip_once = 0;
            else begin
                fb_edge = 1;
                if (extra_once) begin extra_once = 0; extra_arm = 1; end
            end
        end
        if (ph == 3 && extra_arm) begin extra_arm = 0; fb_edge = 1; end
        ph = (ph + 1) % 4;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        tick();
        reg_we = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 0; reg_addr = 2'd2;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R9 reset state
        @(negedge clk);
        check_eq("R9 lock after reset", pll_locked, 0);
        check_eq("R9 sel after reset", clk_sel, 0);
        reg_addr = 2'd0; #1 check_eq("R9 ctrl reg after reset", reg_rdata, 0);
        reg_addr = 2'd1; #1 check_eq("R9 div reg after reset", reg_rdata, 0);
        reg_addr = 2'd2;

        // R3 lock with divide-by-1 (R1 D=0)
        run(100);
        check_eq("R3 no lock before full run", pll_locked, 0);
        run(500);
        check_eq("R3 lock after 128 good periods", pll_locked, 1);
        check_eq("R1 divide-by-1 locked", pll_locked, 1);

        // R2/R4/R6 extra edge slip while locked
        n_evt = 0;
        extra_once = 1;
        run(12);
        check_eq("R2 double edge is slip", pll_locked, 0);
        check_eq("R6 one event on lock loss", n_evt, 1);
        run(40);
        skip_once = 1;
        run(12);
        check_eq("R6 no event while unlocked", n_evt, 1);
        check_eq("R4 still unlocked", pll_locked, 0);

        // R5 writes to status ignored
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        reg_addr = 2'd3; #1 check_eq("R5 addr3 reads zero", reg_rdata, 0);
        reg_addr = 2'd2;

        // R8 manual select, R7 auto bypass
        wr(2'd0, 8'h02);
        run(4);
        check_eq("R8 manual sel while unlocked", clk_sel, 1);
        wr(2'd0, 8'h01);
        run(4);
        check_eq("R7 bypass to reference while unlocked", clk_sel, 0);
        run(600);
        check_eq("R7 sel returns to PLL on relock", clk_sel, 1);
        skip_once = 1;
        run(12);
        check_eq("R7 bypass on lock loss", clk_sel, 0);

        // R1 divide by 4
        gen_div = 3;
        wr(2'd1, 8'd3);
        reg_addr = 2'd1; #1 check_eq("R5 divider readback", reg_rdata, 3);
        reg_addr = 2'd2;
        run(1000);
        check_eq("R1 no lock yet with D=3", pll_locked, 0);
        run(1300);
        check_eq("R1 lock with D=3", pll_locked, 1);
        extra_once = 1;
        run(20);
        check_eq("R4 slip with D=3", pll_locked, 0);
        wr(2'd0, 8'h00);
        run(4);
        check_eq("R8 manual sel to reference", clk_sel, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule